// File: doc/BRIEF.md
# Derived-Value Register File on a Request/Acknowledge Bus

This block is a four-word register file that sits on a simple programmed-I/O bus. The bus has a write channel and a read channel. Each channel has its own request, address and acknowledge signals. Software can store a 32-bit value in either of the two writable words. The block then keeps two further words up to date from them, one holding their difference and one holding their sum. Software can read all four words back but can change only the first two.

A requester raises a request together with its address (and, for writes, its data). It holds them until it sees the matching acknowledge, which is high for exactly one cycle. A request is taken on a rising edge where the request is high and the acknowledge of that channel is low. A request held straight through its acknowledge is therefore taken again one cycle later. The two channels are independent and can both complete in the same cycle.

Top module: `pio_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four words to zero and holds both acknowledges and `rd_data` low.
- R2: Word addresses 0 and 1 hold writable 32-bit words. A completed write stores all 32 data bits, and a later read of that address returns them.
- R3: A write is taken on an edge where `wr_req` is high and `wr_ack` is low. `wr_ack` is then high for exactly the following cycle, and the written word has its new value from that same cycle.
- R4: A read is taken on an edge where `rd_req` is high and `rd_ack` is low. `rd_ack` is then high for exactly the following cycle, with the read value on `rd_data`. `rd_data` is zero in every cycle where `rd_ack` is low.
- R5: Word address 2 reads (word0 − word1) mod 2^32. With word0 = 1 and word1 = 2 it reads 0xFFFFFFFF.
- R6: Word address 3 reads (word0 + word1) mod 2^32. With word0 = 1 and word1 = 2 it reads 0x3.
- R7: Words 2 and 3 follow a change of word 0 or 1 one cycle later. A read taken on the edge right after a write was taken returns the difference and sum of the values from before that write.
- R8: A write to address 2, address 3, or any address from 4 upward is acknowledged like any other write but changes no word. Decoding uses all 17 address bits, so 0x10000 does not alias address 0.
- R9: A read of any address from 4 upward, across all 17 bits, is acknowledged and returns zero.
- R10: A read and a write taken on the same edge are independent. If they target the same word, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request, held until `wr_ack` |
| wr_addr | input | 17 | Write word address, valid while `wr_req` is high |
| wr_data | input | 32 | Write data, valid while `wr_req` is high |
| wr_ack | output | 1 | One-cycle write acknowledge |
| rd_req | input | 1 | Read request, held until `rd_ack` |
| rd_addr | input | 17 | Read word address, valid while `rd_req` is high |
| rd_data | output | 32 | Read data, valid while `rd_ack` is high, zero otherwise |
| rd_ack | output | 1 | One-cycle read acknowledge |

## Verification
A wrong stored word or a wrong difference or sum is visible only through a read. The bench therefore mirrors every word in a behavioural model and compares `rd_data` and both acknowledges on every cycle. A corrupted word shows up one cycle after the first read that is taken on it. A derived word that updates too early or too late by one cycle shows up only in a read placed on the edge right after a write. The bench schedules exactly that overlap. A stuck acknowledge, or a held request that is taken twice in a row, shows at once in the per-cycle comparison of `wr_ack` and `rd_ack`.

// File: rtl/pio_regs_pkg.sv
package pio_regs_pkg;

    // number of words software may write
    localparam int RW_COUNT = 2;
    // number of words computed from the writable ones
    localparam int DERIVED_COUNT = 2;
    // total decoded words
    localparam int WORD_COUNT = RW_COUNT + DERIVED_COUNT;
    // select width for the word index
    localparam int WORD_IDX_W = $clog2(WORD_COUNT);

    // word slots; the address of each word equals its slot number
    typedef enum logic [WORD_IDX_W-1:0] {
        SLOT_RW0  = 2'd0,
        SLOT_RW1  = 2'd1,
        SLOT_DIFF = 2'd2,
        SLOT_SUM  = 2'd3
    } word_slot_e;

endpackage

// File: rtl/pio_wr_port.sv
module pio_wr_port
    import pio_regs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_req,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic                             wr_ack,
    output logic [RW_COUNT-1:0][DATA_W-1:0]  rw_regs
);

    typedef struct packed {
        logic [RW_COUNT-1:0][DATA_W-1:0] regs;
        logic                            ack;
    } wr_state_t;

    wr_state_t st_d;
    wr_state_t st_q;
    logic      take_d;

    // a request is taken only while no acknowledge is on the bus
    always_comb begin
        st_d   = st_q;
        take_d = wr_req && !st_q.ack;
        st_d.ack = take_d;
        if (take_d) begin
            for (int i = 0; i < RW_COUNT; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    st_d.regs[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ack  = st_q.ack;
    assign rw_regs = st_q.regs;

endmodule

// File: rtl/pio_derive.sv
module pio_derive
    import pio_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [RW_COUNT-1:0][DATA_W-1:0]  rw_regs,
    output logic [DATA_W-1:0]                diff,
    output logic [DATA_W-1:0]                sum
);

    typedef struct packed {
        logic [DATA_W-1:0] diff;
        logic [DATA_W-1:0] sum;
    } drv_state_t;

    drv_state_t st_d;
    drv_state_t st_q;

    // wrap-around arithmetic at the data width
    always_comb begin
        st_d.diff = rw_regs[SLOT_RW0] - rw_regs[SLOT_RW1];
        st_d.sum  = rw_regs[SLOT_RW0] + rw_regs[SLOT_RW1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign diff = st_q.diff;
    assign sum  = st_q.sum;

endmodule

// File: rtl/pio_rd_port.sv
module pio_rd_port
    import pio_regs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_req,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [RW_COUNT-1:0][DATA_W-1:0]  rw_regs,
    input  logic [DATA_W-1:0]                diff,
    input  logic [DATA_W-1:0]                sum,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             rd_ack
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ack;
    } rd_state_t;

    logic [WORD_COUNT-1:0][DATA_W-1:0] words;
    logic                              hit;
    logic                              take_d;
    rd_state_t                         st_d;
    rd_state_t                         st_q;

    // gather every decoded word into one indexed array
    for (genvar g = 0; g < RW_COUNT; g++) begin : g_rw
        assign words[g] = rw_regs[g];
    end
    assign words[SLOT_DIFF] = diff;
    assign words[SLOT_SUM]  = sum;

    // the whole address is compared, so high bits never alias
    assign hit = (rd_addr < ADDR_W'(WORD_COUNT));

    always_comb begin
        take_d    = rd_req && !st_q.ack;
        st_d.ack  = take_d;
        st_d.data = '0;
        if (take_d && hit) begin
            st_d.data = words[rd_addr[WORD_IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;
    assign rd_ack  = st_q.ack;

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_regs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ack
);

    logic [RW_COUNT-1:0][DATA_W-1:0] rw_regs;
    logic [DATA_W-1:0]               diff;
    logic [DATA_W-1:0]               sum;

    pio_wr_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ack  (wr_ack),
        .rw_regs (rw_regs)
    );

    pio_derive #(
        .DATA_W (DATA_W)
    ) u_drv (
        .clk     (clk),
        .rst     (rst),
        .rw_regs (rw_regs),
        .diff    (diff),
        .sum     (sum)
    );

    pio_rd_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rw_regs (rw_regs),
        .diff    (diff),
        .sum     (sum),
        .rd_data (rd_data),
        .rd_ack  (rd_ack)
    );

endmodule

// File: rtl/pio_regfile_chk.sv
module pio_regfile_chk
    import pio_regs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             wr_req,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic                             wr_ack,
    input logic                             rd_req,
    input logic [ADDR_W-1:0]                rd_addr,
    input logic [DATA_W-1:0]                rd_data,
    input logic                             rd_ack,
    input logic [RW_COUNT-1:0][DATA_W-1:0]  rw_regs
);

    // R3
    wr_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ack |=> !wr_ack);

    // R3
    wr_take_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> wr_ack);

    // R3
    wr_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ack |-> $past(wr_req));

    // R4
    rd_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rd_ack);

    // R4
    rd_take_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> rd_ack);

    // R4
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_ack |-> (rd_data == '0));

    // R8
    wr_unmapped_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack && (wr_addr >= ADDR_W'(RW_COUNT)))
            |=> $stable(rw_regs));

    // R9
    rd_unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && (rd_addr >= ADDR_W'(WORD_COUNT)))
            |=> (rd_data == '0));

    // R2
    wr_idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && !wr_ack) |=> $stable(rw_regs));

endmodule

bind pio_regfile pio_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_ack  (wr_ack),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_ack  (rd_ack),
    .rw_regs (rw_regs)
);

// File: tb/sim_pio_regfile.sv
`timescale 1ns/1ps
module sim_pio_regfile;

    localparam int AW = 17;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ack;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pio_regfile u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ack  (wr_ack),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_ack  (rd_ack)
    );

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_w0, m_w1, m_dif, m_sum, m_rdata;
    logic          m_wack, m_rack;

    function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
        case (a)
            0: return m_w0;
            1: return m_w1;
            2: return m_dif;
            3: return m_sum;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [DW-1:0] o0, o1, nd;
        logic          nr;
        if (rst) begin
            m_w0 = '0; m_w1 = '0; m_dif = '0; m_sum = '0;
            m_rdata = '0; m_wack = 1'b0; m_rack = 1'b0;
        end else begin
            o0 = m_w0;
            o1 = m_w1;
            nr = rd_req && !m_rack;
            nd = nr ? model_word(rd_addr) : '0;
            if (wr_req && !m_wack) begin
                if (wr_addr == 0) m_w0 = wr_data;
                if (wr_addr == 1) m_w1 = wr_data;
                m_wack = 1'b1;
            end else begin
                m_wack = 1'b0;
            end
            m_dif   = o0 - o1;
            m_sum   = o0 + o1;
            m_rack  = nr;
            m_rdata = nd;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 wr_ack", {31'd0, wr_ack}, {31'd0, m_wack});
            chk("R4 rd_ack", {31'd0, rd_ack}, {31'd0, m_rack});
            chk("R4 rd_data", rd_data, m_rdata);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wr_ack) break;
        end
        chk("R3 write acknowledged", {31'd0, wr_ack}, 32'd1);
        wr_req = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a,
                           input logic [DW-1:0] exp);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rd_ack) break;
        end
        chk({req, " ack"}, {31'd0, rd_ack}, 32'd1);
        chk(req, rd_data, exp);
        rd_req = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 wr_ack after reset", {31'd0, wr_ack}, 32'd0);
        chk("R1 rd_ack after reset", {31'd0, rd_ack}, 32'd0);
        chk("R1 rd_data after reset", rd_data, 32'd0);
        for (int a = 0; a < 4; a++) do_read("R1 word after reset", AW'(a), 32'd0);

        // R2 R5 R6: basic pattern
        do_write(0, 32'd1);
        do_write(1, 32'd2);
        do_read("R2 word0", 0, 32'd1);
        do_read("R2 word1", 1, 32'd2);
        do_read("R5 diff 1-2", 2, 32'hFFFF_FFFF);
        do_read("R6 sum 1+2", 3, 32'h0000_0003);

        // R5 R6: wrap-around pattern
        do_write(0, 32'hFFFF_FFFF);
        do_write(1, 32'h0000_0001);
        do_read("R5 diff wrap", 2, 32'hFFFF_FFFE);
        do_read("R6 sum wrap", 3, 32'h0000_0000);
        do_write(0, 32'hA5A5_0F0F);
        do_write(1, 32'h1234_5678);
        do_read("R2 full width", 0, 32'hA5A5_0F0F);
        do_read("R5 diff mixed", 2, 32'hA5A5_0F0F - 32'h1234_5678);
        do_read("R6 sum mixed", 3, 32'hA5A5_0F0F + 32'h1234_5678);

        // R8: ignored writes
        do_write(2, 32'hDEAD_BEEF);
        do_write(3, 32'hDEAD_BEEF);
        do_write(17'h10000, 32'hCAFE_0000);
        do_write(17'h10001, 32'hCAFE_0001);
        do_write(7, 32'hCAFE_0007);
        do_read("R8 word0 kept", 0, 32'hA5A5_0F0F);
        do_read("R8 word1 kept", 1, 32'h1234_5678);
        do_read("R8 diff kept", 2, 32'hA5A5_0F0F - 32'h1234_5678);
        do_read("R8 sum kept", 3, 32'hA5A5_0F0F + 32'h1234_5678);

        // R9: unmapped reads
        do_read("R9 addr 4", 4, 32'd0);
        do_read("R9 addr 0x10002", 17'h10002, 32'd0);
        do_read("R9 addr 0x1FFFF", 17'h1FFFF, 32'd0);

        // R7: read taken on the edge right after a write
        do_write(0, 32'd10);
        do_write(1, 32'd4);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 0; wr_data = 32'd20;
        @(negedge clk);
        chk("R7 write ack", {31'd0, wr_ack}, 32'd1);
        wr_req = 1'b0;
        rd_req = 1'b1; rd_addr = 2;
        @(negedge clk);
        chk("R7 read ack", {31'd0, rd_ack}, 32'd1);
        chk("R7 stale diff", rd_data, 32'd6);
        rd_req = 1'b0;
        do_read("R7 updated diff", 2, 32'd16);
        do_read("R7 updated sum", 3, 32'd24);

        // R10: same-edge read and write of one word
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 1; wr_data = 32'd99;
        rd_req = 1'b1; rd_addr = 1;
        @(negedge clk);
        chk("R10 both acks", {30'd0, wr_ack, rd_ack}, 32'd3);
        chk("R10 old value read", rd_data, 32'd4);
        wr_req = 1'b0; rd_req = 1'b0;
        do_read("R10 new value", 1, 32'd99);

        // R3 R4: requests held through their acknowledges
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 0; wr_data = 32'd5;
        rd_req = 1'b1; rd_addr = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 held write alternates", {31'd0, wr_ack}, (i % 2 == 0) ? 32'd1 : 32'd0);
            chk("R4 held read alternates", {31'd0, rd_ack}, (i % 2 == 0) ? 32'd1 : 32'd0);
        end
        wr_req = 1'b0; rd_req = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset in mid-operation clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_read("R1 word0 after second reset", 0, 32'd0);
        do_read("R1 sum after second reset", 3, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule